// File: doc/BRIEF.md
# Three-Wire Serial Control Latch

This block is a small control register that a host loads by toggling general-purpose pins. Three lines carry the word: a data line, a shift clock and a load strobe. A fourth line acts as a transfer qualifier that the host raises together with the load strobe. The host sets a bit on the data line while the shift clock is low and raises the shift clock to capture it. It repeats this for every bit of the word, most significant bit first, with the load strobe held low. It then drops the clock and data lines and pulses the load strobe with the qualifier high. That pulse copies the shifted word into the parallel output latches.

The outputs drive static board controls such as mute and chip-disable lines. They hold their value between loads, so a half-shifted word never appears on them. All four host lines arrive asynchronously. They pass through a synchronizer of configurable depth and are edge-detected in the system clock domain. The word width and the qualifier requirement are parameters.

Top module: `scl_latch_top`

## Requirements
- R1: After reset, ctrl_out is all zeros and the internal shift register is all zeros. A qualified load with no shifts in between therefore drives 0000 onto ctrl_out.
- R2: A data bit is captured only on a rising edge of ser_clk. Changes on ser_data while ser_clk stays steady, and falling edges of ser_clk, capture nothing.
- R3: Bits are shifted most significant bit first. After WORD_W captured bits, the first bit captured appears on ctrl_out[WORD_W-1] and the last on ctrl_out[0].
- R4: ctrl_out changes only in response to a qualified rising edge of ser_load, and it updates no later than four system clock cycles after that edge. Shifting alone never alters ctrl_out.
- R5: With QUAL_EN=1, a rising edge of ser_load while ser_qual is low leaves ctrl_out unchanged.
- R6: Rising edges of ser_clk while ser_load is high shift nothing.
- R7: When more than WORD_W bits are shifted before a load, only the last WORD_W bits captured are transferred.
- R8: A load does not clear the shift register. A later qualified load with no new shifts transfers the same word again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_data | input | 1 | Serial data line, asynchronous |
| ser_clk | input | 1 | Shift clock from host, asynchronous; rising edge captures data |
| ser_load | input | 1 | Load strobe, asynchronous; rising edge transfers the word |
| ser_qual | input | 1 | Transfer qualifier raised together with the load strobe |
| ctrl_out | output | WORD_W | Latched parallel control outputs |

## Verification
The bench builds the block with its defaults: a 4-bit word, a two-stage synchronizer and the qualifier required. These values let a small table of words cover every output pattern that matters. They also let the bench exercise unqualified loads next to qualified ones. Because the word is short, over-length shifts, clock edges during a held load and repeated loads with no new bits each take only a few dozen host edges to set up and observe at ctrl_out.

// File: rtl/scl_pkg.sv
package scl_pkg;

    // Decoded host event for one system clock cycle
    typedef enum logic [1:0] {
        EV_IDLE    = 2'd0,
        EV_SHIFT   = 2'd1,
        EV_LATCH   = 2'd2,
        EV_BLOCKED = 2'd3
    } scl_event_e;

endpackage

// File: rtl/scl_sync.sv
module scl_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);

    typedef struct packed {
        logic [STAGES-1:0][W-1:0] pipe;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.pipe[0] = async_in;
        for (int i = 1; i < STAGES; i++) begin
            st_d.pipe[i] = st_q.pipe[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sync_out = st_q.pipe[STAGES-1];

endmodule

// File: rtl/scl_edge.sv
module scl_edge #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] level,
    output logic [W-1:0] rise
);

    typedef struct packed {
        logic [W-1:0] prev;
    } edge_st_t;

    edge_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = level;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rise = level & ~st_q.prev;

    // A detected rising edge lasts a single cycle on each line (supports R2, R4)
    p_single_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (|rise) |=> ((rise & $past(rise)) == '0));

endmodule

// File: rtl/scl_shreg.sv
module scl_shreg #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_en,
    input  logic         din,
    output logic [W-1:0] word
);

    typedef struct packed {
        logic [W-1:0] bits;
    } shreg_st_t;

    shreg_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (shift_en) begin
            // Earlier bits move toward the MSB, newest lands at bit 0
            st_d.bits = {st_q.bits[W-2:0], din};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign word = st_q.bits;

    // Without a shift request the stored word does not move (R2)
    p_hold_no_shift_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(word));

    // A shift moves the old MSB-side bits up by one place (R3)
    p_msb_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> (word[W-1:1] == $past(word[W-2:0])));

endmodule

// File: rtl/scl_latch_top.sv
module scl_latch_top
    import scl_pkg::*;
#(
    parameter int WORD_W      = 4,
    parameter int SYNC_STAGES = 2,
    parameter bit QUAL_EN     = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_data,
    input  logic              ser_clk,
    input  logic              ser_load,
    input  logic              ser_qual,
    output logic [WORD_W-1:0] ctrl_out
);

    localparam int N_LINES = 4;
    localparam int IDX_DAT = 0;
    localparam int IDX_CLK = 1;
    localparam int IDX_LD  = 2;
    localparam int IDX_QL  = 3;

    logic [N_LINES-1:0] raw_lines;
    logic [N_LINES-1:0] syn_lines;
    logic [1:0]         rises;
    logic               clk_rise;
    logic               load_rise;
    logic               qual_ok;
    logic               shift_en;
    logic [WORD_W-1:0]  shift_word;
    scl_event_e         ev;

    assign raw_lines = {ser_qual, ser_load, ser_clk, ser_data};

    // All host lines share one synchronizer so they keep their relative timing
    scl_sync #(
        .W      (N_LINES),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (raw_lines),
        .sync_out (syn_lines)
    );

    scl_edge #(
        .W (2)
    ) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .level ({syn_lines[IDX_LD], syn_lines[IDX_CLK]}),
        .rise  (rises)
    );

    assign clk_rise  = rises[0];
    assign load_rise = rises[1];

    generate
        if (QUAL_EN) begin : g_qual
            assign qual_ok = syn_lines[IDX_QL];
        end else begin : g_noqual
            assign qual_ok = 1'b1;
        end
    endgenerate

    // Event decode: a load edge wins, shifts are frozen while load is high
    always_comb begin
        ev = EV_IDLE;
        if (load_rise) begin
            ev = qual_ok ? EV_LATCH : EV_BLOCKED;
        end else if (clk_rise && !syn_lines[IDX_LD]) begin
            ev = EV_SHIFT;
        end
    end

    assign shift_en = (ev == EV_SHIFT);

    scl_shreg #(
        .W (WORD_W)
    ) u_shreg (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (shift_en),
        .din      (syn_lines[IDX_DAT]),
        .word     (shift_word)
    );

    typedef struct packed {
        logic [WORD_W-1:0] ctrl;
    } out_st_t;

    out_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ev == EV_LATCH) begin
            st_d.ctrl = shift_word;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctrl_out = st_q.ctrl;

    // Outputs move only in the cycle after a qualified load edge (R4)
    p_out_only_on_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ctrl_out) |-> ($past(ev) == EV_LATCH));

    // An unqualified load edge leaves the outputs alone (R5)
    p_blocked_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ev == EV_BLOCKED) |=> $stable(ctrl_out));

    // Shift-clock edges while load is held high do not reach the shift register (R6)
    p_no_shift_in_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_rise && syn_lines[IDX_LD]) |-> !shift_en);

    // A qualified load transfers the current shift register contents (R8)
    p_latch_copies_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ev == EV_LATCH) |=> (ctrl_out == $past(shift_word)));

endmodule

// File: tb/sim_scl_latch_top.sv
module sim_scl_latch_top;

    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         ser_data = 1'b0;
    logic         ser_clk = 1'b0;
    logic         ser_load = 1'b0;
    logic         ser_qual = 1'b0;
    logic [W-1:0] ctrl_out;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    scl_latch_top #(
        .WORD_W      (W),
        .SYNC_STAGES (2),
        .QUAL_EN     (1'b1)
    ) u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .ser_data (ser_data),
        .ser_clk  (ser_clk),
        .ser_load (ser_load),
        .ser_qual (ser_qual),
        .ctrl_out (ctrl_out)
    );

    // {qual, word}: words cover all-zero, all-one, alternating and single bits
    localparam logic [4:0] VEC [8] = '{
        5'b1_1010, 5'b1_0101, 5'b1_1111, 5'b0_0011,
        5'b1_1000, 5'b1_0001, 5'b0_1110, 5'b1_0000
    };

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic shift_bit(input logic b);
        ser_data = b;
        wait_cyc(4);
        ser_clk = 1'b1;
        wait_cyc(4);
        ser_clk = 1'b0;
        wait_cyc(4);
    endtask

    task automatic shift_word(input logic [W-1:0] w);
        for (int i = W - 1; i >= 0; i--) shift_bit(w[i]);
        ser_data = 1'b0;
    endtask

    task automatic load_pulse(input logic q);
        ser_qual = q;
        ser_load = 1'b1;
        wait_cyc(4);
        ser_load = 1'b0;
        ser_qual = 1'b0;
        wait_cyc(4);
    endtask

    task automatic check(input string req, input logic [W-1:0] exp);
        n_checks++;
        if (ctrl_out !== exp) begin
            n_fails++;
            $display("FAIL %s: ctrl_out=%b expected=%b", req, ctrl_out, exp);
        end
    endtask

    initial begin
        wait_cyc(200000);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: run hung, actual=timeout expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] model;
        wait_cyc(3);
        check("R1 reset outputs", 4'b0000);
        rst_n = 1'b1;
        wait_cyc(3);
        check("R1 after release", 4'b0000);
        load_pulse(1'b1);
        check("R1 shift register clear", 4'b0000);

        model = '0;
        for (int k = 0; k < 8; k++) begin
            shift_word(VEC[k][3:0]);
            check("R4 unchanged after shifting", model);
            load_pulse(VEC[k][4]);
            if (VEC[k][4]) model = VEC[k][3:0];
            check(VEC[k][4] ? "R3 vector load" : "R5 vector unqualified", model);
        end

        // R4: partial shift does not disturb outputs
        shift_word(4'b0110);
        load_pulse(1'b1);
        shift_bit(1'b1);
        shift_bit(1'b0);
        check("R4 partial shift", 4'b0110);
        shift_bit(1'b0);
        shift_bit(1'b1);
        load_pulse(1'b1);
        check("R3 first bit reaches MSB", 4'b1001);

        // R2: data toggling with clock steady, data change while clock high
        shift_word(4'b1100);
        for (int i = 0; i < 5; i++) begin
            ser_data = ~ser_data;
            wait_cyc(3);
        end
        ser_data = 1'b0;
        load_pulse(1'b1);
        check("R2 data without clock edge", 4'b1100);
        shift_bit(1'b1);
        shift_bit(1'b1);
        shift_bit(1'b1);
        ser_data = 1'b0;
        wait_cyc(4);
        ser_clk = 1'b1;
        wait_cyc(4);
        ser_data = 1'b1;
        wait_cyc(4);
        ser_clk = 1'b0;
        wait_cyc(4);
        ser_data = 1'b0;
        load_pulse(1'b1);
        check("R2 sampled at rising edge only", 4'b1110);

        // R6: clock edges while load is held high
        shift_word(4'b0101);
        load_pulse(1'b1);
        ser_load = 1'b1;
        wait_cyc(4);
        for (int i = 0; i < W; i++) shift_bit(1'b1);
        ser_load = 1'b0;
        wait_cyc(4);
        check("R6 load-high unqualified", 4'b0101);
        shift_bit(1'b0);
        shift_bit(1'b0);
        load_pulse(1'b1);
        check("R6 shifts in load ignored", 4'b0100);

        // R7: over-length shift keeps the last W bits
        shift_bit(1'b1);
        shift_bit(1'b1);
        shift_bit(1'b0);
        shift_bit(1'b0);
        shift_bit(1'b1);
        shift_bit(1'b0);
        load_pulse(1'b1);
        check("R7 over-length shift", 4'b0010);

        // R5 and R8: blocked load, then qualified reloads
        shift_word(4'b1001);
        load_pulse(1'b0);
        check("R5 unqualified load", 4'b0010);
        load_pulse(1'b1);
        check("R8 load after blocked", 4'b1001);
        load_pulse(1'b1);
        check("R8 repeated load", 4'b1001);

        // R1: reset mid-operation clears everything
        shift_word(4'b1111);
        rst_n = 1'b0;
        wait_cyc(2);
        check("R1 reset mid-run", 4'b0000);
        rst_n = 1'b1;
        wait_cyc(3);
        load_pulse(1'b1);
        check("R1 shift register cleared by reset", 4'b0000);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule